// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a data cache controller that sits between a processor load/store port and a slower next-level memory. It holds 8 KB in two ways of 256 sets, and each line holds four 32-bit words. Stores use a write-back, write-allocate rule: a store that hits only marks the line dirty, and a store that misses first brings the line in and then merges the bytes into it.

On a miss the controller picks a victim way. An empty way is always used first. Otherwise a run-time select input chooses between evicting the less recently used way and evicting the most recently used way. A dirty victim is written to the next level as a full line. That write occupies a fixed number of cycles, and only after it ends does the line-wide refill read start. A clean victim is simply overwritten. The processor keeps its request asserted until ready is returned. Two 32-bit counters report how many requests hit and how many missed.

Top module: `dcache2w`

## Requirements
- R1: A read that hits returns the addressed word with cpu_ready high in the same cycle the request is presented.
- R2: The address is split as word offset bits 3:2, set index bits 11:4 and tag bits 31:12. Every word of a resident line hits.
- R3: A store that hits writes only the byte lanes whose cpu_be bit is set (bit n covers data bits 8n+7:8n) and marks the line dirty.
- R4: On a miss, an invalid way of the set is filled before any replacement policy is applied.
- R5: With repl_mru low and both ways valid, the way not used most recently is evicted.
- R6: With repl_mru high and both ways valid, the way used most recently is evicted.
- R7: Evicting a dirty line holds mem_req and mem_we high with the victim line address and data for exactly 10 cycles. The refill read request follows directly after.
- R8: A clean victim causes no memory write. Its miss takes only the refill, so ready arrives 2 cycles after the refill acknowledge latency.
- R9: A store that misses fetches the line and then merges the store bytes into it. The line is dirty afterwards.
- R10: cpu_ready stays low while a miss is serviced and rises only when the original request completes.
- R11: hit_count and miss_count clear on reset. Each request adds exactly one to one of them, and the cycle that completes a refilled request is not counted as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte-lane enables |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| repl_mru | input | 1 | 0 = evict least recently used, 1 = evict most recently used |
| mem_req | output | 1 | Next-level request |
| mem_we | output | 1 | Next-level request is a line write |
| mem_addr | output | 32 | Line address (bits 3:0 zero) |
| mem_wdata | output | 128 | Line being written back, word n in bits 32n+31:32n |
| mem_ack | input | 1 | Refill data valid |
| mem_rdata | input | 128 | Refill line, word n in bits 32n+31:32n |
| hit_count | output | 32 | Number of hits |
| miss_count | output | 32 | Number of misses |

## Verification
A store miss is where two functions land in the same cycle. The request completes on the line that was just refilled, so that cycle must both merge the store bytes into the fresh line and leave the hit counter alone. The bench provokes this with a partial-lane store and a full-lane store to lines that are not resident. It judges the result three ways: by reading the words back, by evicting the line and checking that the written-back data carries the merged bytes, and by comparing both counters with totals kept independently in the bench.

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int NSETS  = 256,
  parameter int WB_LAT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_req,
  input  logic         cpu_we,
  input  logic [31:0]  cpu_addr,
  input  logic [31:0]  cpu_wdata,
  input  logic [3:0]   cpu_be,
  output logic         cpu_ready,
  output logic [31:0]  cpu_rdata,
  input  logic         repl_mru,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [127:0] mem_wdata,
  input  logic         mem_ack,
  input  logic [127:0] mem_rdata,
  output logic [31:0]  hit_count,
  output logic [31:0]  miss_count
);
  localparam int IDX_W = $clog2(NSETS);
  localparam int TAG_W = 32 - IDX_W - 4;
  localparam int CNT_W = $clog2(WB_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;
  st_t st;

  logic [31:0]      dat0 [NSETS*4];
  logic [31:0]      dat1 [NSETS*4];
  logic [TAG_W-1:0] tag0 [NSETS];
  logic [TAG_W-1:0] tag1 [NSETS];
  logic [NSETS-1:0] vld0, vld1, drt0, drt1, mru;
  logic             vway, pick, replay;
  logic [CNT_W-1:0] wb_cnt;

  wire [1:0]       woff = cpu_addr[3:2];
  wire [IDX_W-1:0] idx  = cpu_addr[IDX_W+3:4];
  wire [TAG_W-1:0] tg   = cpu_addr[31:IDX_W+4];
  wire [IDX_W+1:0] widx = {idx, woff};

  wire hit0   = vld0[idx] && tag0[idx] == tg;
  wire hit1   = vld1[idx] && tag1[idx] == tg;
  wire hit    = hit0 || hit1;
  wire lookup = st == S_IDLE && cpu_req;
  wire vdirty = pick ? drt1[idx] : drt0[idx];
  wire [TAG_W-1:0] vtag = vway ? tag1[idx] : tag0[idx];

  always_comb begin
    if (!vld0[idx])      pick = 1'b0;
    else if (!vld1[idx]) pick = 1'b1;
    else                 pick = repl_mru ? mru[idx] : ~mru[idx];
  end

  assign cpu_ready = lookup && hit;
  assign cpu_rdata = hit1 ? dat1[widx] : dat0[widx];
  assign mem_req   = st != S_IDLE;
  assign mem_we    = st == S_WB;
  assign mem_addr  = (st == S_WB) ? {vtag, idx, 4'b0} : {tg, idx, 4'b0};

  always_comb
    for (int w = 0; w < 4; w++)
      mem_wdata[32*w +: 32] = vway ? dat1[{idx, 2'(w)}] : dat0[{idx, 2'(w)}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      vld0 <= '0; vld1 <= '0; drt0 <= '0; drt1 <= '0; mru <= '0;
      vway <= 1'b0; replay <= 1'b0; wb_cnt <= '0;
      hit_count <= '0; miss_count <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          if (hit) begin
            if (!replay) hit_count <= hit_count + 32'd1;
            replay <= 1'b0;
            mru[idx] <= hit1;
            if (cpu_we) begin
              if (hit1) drt1[idx] <= 1'b1;
              else      drt0[idx] <= 1'b1;
            end
          end else begin
            miss_count <= miss_count + 32'd1;
            vway <= pick;
            wb_cnt <= '0;
            st <= vdirty ? S_WB : S_FILL;
          end
        end
        S_WB: begin
          wb_cnt <= wb_cnt + 1'b1;
          if (wb_cnt == CNT_W'(WB_LAT - 1)) st <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          if (vway) begin vld1[idx] <= 1'b1; drt1[idx] <= 1'b0; end
          else      begin vld0[idx] <= 1'b1; drt0[idx] <= 1'b0; end
          mru[idx] <= vway;
          replay <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ack) begin
      if (vway) tag1[idx] <= tg;
      else      tag0[idx] <= tg;
      for (int w = 0; w < 4; w++) begin
        if (vway) dat1[{idx, 2'(w)}] <= mem_rdata[32*w +: 32];
        else      dat0[{idx, 2'(w)}] <= mem_rdata[32*w +: 32];
      end
    end
    if (cpu_ready && cpu_we) begin
      for (int b = 0; b < 4; b++)
        if (cpu_be[b]) begin
          if (hit1) dat1[widx][8*b +: 8] <= cpu_wdata[8*b +: 8];
          else      dat0[widx][8*b +: 8] <= cpu_wdata[8*b +: 8];
        end
    end
  end

  logic        past_ok;
  logic [15:0] wb_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      wb_run  <= '0;
    end else begin
      past_ok <= 1'b1;
      if (mem_req && mem_we) wb_run <= (past_ok && $past(mem_req && mem_we)) ? wb_run + 16'd1 : 16'd1;
    end
  end

  AST_WB_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mem_req && mem_we) && !(mem_req && mem_we)) |-> wb_run == 16'(WB_LAT)); // R7
  AST_FILL_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mem_req && mem_we) && !mem_we) |-> mem_req); // R7
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_req && !mem_req)); // R10
  AST_MISS_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && miss_count != $past(miss_count)) |-> mem_req); // R10
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (hit_count == $past(hit_count) || hit_count == $past(hit_count) + 32'd1)); // R11
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 32'd1)); // R11
endmodule

// File: tb/test_dcache2w.sv
module test_dcache2w;
  localparam int PERIOD     = 10;
  localparam int REFILL_LAT = 3;
  localparam int WB_LAT     = 10;
  localparam int CLEAN_MISS = REFILL_LAT + 2;
  localparam int DIRTY_MISS = WB_LAT + REFILL_LAT + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0, repl_mru = 1'b0, mem_ack = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic cpu_ready, mem_req, mem_we;
  logic [31:0] cpu_rdata, mem_addr, hit_count, miss_count;
  logic [127:0] mem_wdata, mem_rdata = '0;

  int checks = 0, fails = 0, exp_hits = 0, exp_misses = 0;
  int wb_cycles = 0, rd_cnt = 0;
  logic [31:0] wb_addr = '0;
  logic [127:0] bmem [logic [31:0]];

  always #(PERIOD/2) clk = ~clk;

  dcache2w #(.NSETS(256), .WB_LAT(WB_LAT)) i_dcache2w (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .repl_mru(repl_mru), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic logic [31:0] init_word(logic [31:0] a);
    return a ^ 32'h5A5A_5A5A;
  endfunction

  function automatic logic [127:0] line_of(logic [31:0] la);
    logic [127:0] l;
    if (bmem.exists(la)) return bmem[la];
    for (int w = 0; w < 4; w++) l[32*w +: 32] = init_word(la + 32'(4*w));
    return l;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  initial forever begin
    @(negedge clk);
    if (mem_req && mem_we) begin
      bmem[mem_addr] = mem_wdata;
      wb_addr = mem_addr;
      wb_cycles++;
    end
    if (mem_req && !mem_we) begin
      rd_cnt++;
      if (rd_cnt == REFILL_LAT) begin
        mem_ack = 1'b1;
        mem_rdata = line_of(mem_addr);
      end else mem_ack = 1'b0;
    end else begin
      rd_cnt = 0;
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input int exp_cyc, input string tag,
                        output logic [31:0] rd);
    int cyc;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    wb_cycles = 0;
    cyc = 1;
    #1;
    while (!cpu_ready && cyc < 200) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (exp_cyc == 1) exp_hits++; else exp_misses++;
    chk(cyc == exp_cyc, {tag, " latency"}, 128'(cyc), 128'(exp_cyc));
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input int exp_cyc, input string tag);
    logic [31:0] r;
    access(1'b0, a, '0, 4'h0, exp_cyc, tag, r);
    chk(r == exp, {tag, " data"}, 128'(r), 128'(exp));
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input int exp_cyc, input string tag);
    logic [31:0] r;
    access(1'b1, a, d, be, exp_cyc, tag, r);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R10 idle after reset", {cpu_ready, mem_req}, 0);
    chk(hit_count == 0 && miss_count == 0, "R11 counters cleared", {hit_count, miss_count}, 0);
  endtask

  task automatic t_basic;
    rd_chk(32'h1000, init_word(32'h1000), CLEAN_MISS, "R8 R10 cold read miss");
    rd_chk(32'h1004, init_word(32'h1004), 1, "R1 read hit word1");
    rd_chk(32'h100C, init_word(32'h100C), 1, "R2 read hit word3");
  endtask

  task automatic t_invalid_first;
    rd_chk(32'h2000, init_word(32'h2000), CLEAN_MISS, "R4 second tag fills empty way");
    rd_chk(32'h1000, init_word(32'h1000), 1, "R4 first tag kept");
    rd_chk(32'h2000, init_word(32'h2000), 1, "R4 second tag resident");
  endtask

  task automatic t_lru;
    repl_mru = 1'b0;
    rd_chk(32'h3000, init_word(32'h3000), CLEAN_MISS, "R5 third tag miss");
    rd_chk(32'h2000, init_word(32'h2000), 1, "R5 recent way kept");
    rd_chk(32'h1000, init_word(32'h1000), CLEAN_MISS, "R5 older way evicted");
  endtask

  task automatic t_mru;
    repl_mru = 1'b1;
    rd_chk(32'h3000, init_word(32'h3000), CLEAN_MISS, "R6 miss under mru");
    rd_chk(32'h2000, init_word(32'h2000), 1, "R6 older way kept");
    rd_chk(32'h1000, init_word(32'h1000), CLEAN_MISS, "R6 evicted way missing");
    rd_chk(32'h3000, init_word(32'h3000), 1, "R6 less recent way kept");
    repl_mru = 1'b0;
  endtask

  task automatic t_dirty;
    logic [31:0] m;
    logic [127:0] l;
    m = merge(init_word(32'h4014), 32'hDEAD_BEEF, 4'b0101);
    rd_chk(32'h4010, init_word(32'h4010), CLEAN_MISS, "R3 fill line");
    wr(32'h4014, 32'hDEAD_BEEF, 4'b0101, 1, "R3 store hit");
    rd_chk(32'h4014, m, 1, "R3 byte merge");
    rd_chk(32'h4010, init_word(32'h4010), 1, "R3 neighbour word untouched");
    rd_chk(32'h5010, init_word(32'h5010), CLEAN_MISS, "R4 second way");
    rd_chk(32'h6010, init_word(32'h6010), DIRTY_MISS, "R7 dirty eviction latency");
    chk(wb_cycles == WB_LAT, "R7 write-back cycles", 128'(wb_cycles), 128'(WB_LAT));
    chk(wb_addr == 32'h4010, "R7 write-back address", 128'(wb_addr), 128'h4010);
    l = line_of(32'h4010);
    chk(l[63:32] == m, "R7 write-back data", 128'(l[63:32]), 128'(m));
    rd_chk(32'h7010, init_word(32'h7010), CLEAN_MISS, "R8 clean victim");
    chk(wb_cycles == 0, "R8 no write-back", 128'(wb_cycles), 0);
    rd_chk(32'h6010, init_word(32'h6010), 1, "R8 other way kept");
  endtask

  task automatic t_write_miss;
    logic [127:0] l;
    logic [31:0] m;
    m = merge(init_word(32'hB018), 32'hCAFE_0011, 4'b1000);
    wr(32'h8024, 32'h1234_5678, 4'hF, CLEAN_MISS, "R9 store miss");
    rd_chk(32'h8024, 32'h1234_5678, 1, "R9 merged store");
    rd_chk(32'h8020, init_word(32'h8020), 1, "R9 rest of line fetched");
    rd_chk(32'h9020, init_word(32'h9020), CLEAN_MISS, "R9 fill other way");
    rd_chk(32'hA020, init_word(32'hA020), DIRTY_MISS, "R9 allocated line is dirty");
    l = line_of(32'h8020);
    chk(l[63:32] == 32'h1234_5678, "R9 written back merged word", 128'(l[63:32]), 128'h12345678);
    wr(32'hB018, 32'hCAFE_0011, 4'b1000, CLEAN_MISS, "R9 partial store miss");
    rd_chk(32'hB018, m, 1, "R9 partial merge after fill");
  endtask

  task automatic t_counts;
    @(negedge clk);
    chk(hit_count == 32'(exp_hits), "R11 hit count", 128'(hit_count), 128'(exp_hits));
    chk(miss_count == 32'(exp_misses), "R11 miss count", 128'(miss_count), 128'(exp_misses));
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_invalid_first;
    t_lru;
    t_mru;
    t_counts;
    t_dirty;
    t_write_miss;
    t_counts;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule